// File: doc/BRIEF.md
# Channel-Control Register Target for a Two-Wire Bus Switch

This block is the configuration endpoint of a four-way two-wire bus switch. It watches the upstream clock and data lines, oversampling them from a system clock that runs far faster than the bus. It frames each transfer between START and STOP. It answers only to a 7-bit address made of the fixed pattern `1110` followed by three strap inputs. It holds one 8-bit control byte. Bit 7 of that byte selects which way the switch forwards the clock. Bits 3..0 switch the four downstream channels on.

A controller writes the byte in a single-byte write frame. The written byte waits in a pending slot and reaches the register outputs only when a STOP closes the frame. If a new START arrives before that STOP, the pending byte is dropped. A read frame returns the live register with bits 6..4 forced to zero.

The block drives the data line only through a pull-low enable, which feeds an open-drain pad. After reset is released, an internal power-up interval runs, and the block ignores the bus until that interval ends.

Top module: `i2c_chanctl_target`

## Requirements
- R1: While `rst_n` is low, `clk_dir_o` is 0, `chan_en_o` is all zeros and `sda_pull_o` is 0; a reset issued after a write clears the register.
- R2: For `POR_CYCLES` clocks after `rst_n` rises, bus traffic is ignored: a frame whose START falls in that window gets no ACK and changes no output.
- R3: The address byte is ACKed (data pulled low in the ninth clock) only when its top seven bits equal `1110` followed by `strap_i[2:0]`, bit 0 being 0 for write and 1 for read; any other address gets no ACK and leaves the outputs unchanged.
- R4: In a write, the data byte's bit 7 becomes `clk_dir_o` (1 = reversed direction) and bits 3..0 become `chan_en_o[3:0]`; bits 6..4 have no effect.
- R5: A written byte leaves the outputs unchanged after its data ACK and appears on them only once a STOP (data rising while clock is high) is received.
- R6: A read returns, MSB first, {bit 7, 0, 0, 0, bits 3..0} of the live register; after a controller ACK the same byte is sent again, and after a NACK the target releases the line.
- R7: A START (data falling while clock is high) received before the STOP of a write discards the pending byte; the outputs keep their old value.
- R8: `sda_pull_o` changes only while the bus clock is low, and it is released in the low phase that follows the ninth clock of each ACKed byte.
- R9: The target stays addressable and writable from the upstream lines with `clk_dir_o` at 1.
- R10: The data byte of an addressed write is ACKed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low reset; clears the register |
| strap_i | input | 3 | Low three address bits taken from straps |
| scl_i | input | 1 | Upstream bus clock level |
| sda_i | input | 1 | Upstream bus data level |
| sda_pull_o | output | 1 | 1 pulls the data line low through an open-drain pad |
| clk_dir_o | output | 1 | Clock direction: 0 forward, 1 reversed |
| chan_en_o | output | 4 | Downstream channel enables, bit n for channel n |

## Verification
On every cycle, the assertions check four things. The pull-low output only asserts while the synchronised clock is low. The register outputs move only on the cycle after a STOP is detected. The block stays silent and cleared during the power-up window. The line is free right after any START or STOP. Only the bench's frames can show the rest: address matching across every strap value, the masking of bits 6..4, the MSB-first read data, and that a repeated START throws away a pending write.

// File: rtl/i2c_chanctl_pkg.sv
package i2c_chanctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ADDR   = 3'd1,
      ST_ACK_A  = 3'd2,
      ST_WR     = 3'd3,
      ST_ACK_W  = 3'd4,
      ST_RD     = 3'd5,
      ST_RD_ACK = 3'd6
   } eng_state_t;

   localparam int CTRL_W  = 8;
   localparam int DIR_BIT = 7;
   localparam int MAX_CH  = 4;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   localparam int LINES = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [LINES-1:0] raw;
   logic [LINES-1:0] synced;
   logic [LINES-1:0] prev;

   assign raw = {sda_i, scl_i};

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[SYNC_STAGES-2:0], raw[l]};
      end
      assign synced[l] = chain[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '1;
      else        prev <= synced;
   end

   assign scl_o      = synced[0];
   assign sda_o      = synced[1];
   assign scl_rise_o = synced[0] & ~prev[0];
   assign scl_fall_o = ~synced[0] & prev[0];
   assign start_o    = synced[0] & prev[0] & prev[1] & ~synced[1];
   assign stop_o     = synced[0] & prev[0] & ~prev[1] & synced[1];

endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
   import i2c_chanctl_pkg::*;
#(
   parameter logic [3:0] ADDR_FIXED = 4'b1110,
   parameter int         STRAP_W    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ready_i,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               sda_s_i,
   input  logic               scl_rise_i,
   input  logic               scl_fall_i,
   input  logic               start_i,
   input  logic               stop_i,
   input  logic [CTRL_W-1:0]  rd_byte_i,
   output logic               pull_o,
   output logic               capt_o,
   output logic [CTRL_W-1:0]  capt_byte_o
);

   localparam int ADDR_W = 4 + STRAP_W;

   if (ADDR_W != 7) begin : g_bad_addr
      $error("fixed bits plus straps must form a 7-bit address");
   end

   eng_state_t        st;
   logic [2:0]        bitn;
   logic [CTRL_W-1:0] sh;
   logic [CTRL_W-1:0] rd_sh;
   logic [CTRL_W-1:0] rx_byte;
   logic              addr_hit;

   assign rx_byte  = {sh[CTRL_W-2:0], sda_s_i};
   assign addr_hit = (rx_byte[CTRL_W-1:1] == {ADDR_FIXED, strap_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         bitn        <= '0;
         sh          <= '0;
         rd_sh       <= '0;
         pull_o      <= 1'b0;
         capt_o      <= 1'b0;
         capt_byte_o <= '0;
      end else if (!ready_i) begin
         st          <= ST_IDLE;
         bitn        <= '0;
         sh          <= '0;
         rd_sh       <= '0;
         pull_o      <= 1'b0;
         capt_o      <= 1'b0;
      end else begin
         capt_o <= 1'b0;
         if (start_i) begin
            st     <= ST_ADDR;
            bitn   <= '0;
            pull_o <= 1'b0;
         end else if (stop_i) begin
            st     <= ST_IDLE;
            bitn   <= '0;
            pull_o <= 1'b0;
         end else begin
            if (scl_rise_i) begin
               case (st)
                  ST_ADDR: begin
                     sh   <= rx_byte;
                     bitn <= bitn + 3'd1;
                     if (bitn == 3'd7) st <= addr_hit ? ST_ACK_A : ST_IDLE;
                  end
                  ST_ACK_A: begin
                     bitn <= '0;
                     if (sh[0]) begin
                        st    <= ST_RD;
                        rd_sh <= rd_byte_i;
                     end else begin
                        st <= ST_WR;
                     end
                  end
                  ST_WR: begin
                     sh   <= rx_byte;
                     bitn <= bitn + 3'd1;
                     if (bitn == 3'd7) begin
                        st          <= ST_ACK_W;
                        capt_o      <= 1'b1;
                        capt_byte_o <= rx_byte;
                     end
                  end
                  ST_ACK_W: st <= ST_IDLE;
                  ST_RD: begin
                     bitn <= bitn + 3'd1;
                     if (bitn == 3'd7) st <= ST_RD_ACK;
                  end
                  ST_RD_ACK: begin
                     if (!sda_s_i) begin
                        st    <= ST_RD;
                        rd_sh <= rd_byte_i;
                        bitn  <= '0;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
                  default: ;
               endcase
            end
            if (scl_fall_i) begin
               case (st)
                  ST_ACK_A, ST_ACK_W: pull_o <= 1'b1;
                  ST_RD: begin
                     pull_o <= ~rd_sh[CTRL_W-1];
                     rd_sh  <= {rd_sh[CTRL_W-2:0], 1'b0};
                  end
                  default: pull_o <= 1'b0;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/chanctl_store.sv
module chanctl_store
   import i2c_chanctl_pkg::*;
#(
   parameter int CH_COUNT   = 4,
   parameter int POR_CYCLES = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                capt_i,
   input  logic [CTRL_W-1:0]   capt_byte_i,
   input  logic                drop_i,
   input  logic                commit_i,
   output logic                ready_o,
   output logic                dir_o,
   output logic [CH_COUNT-1:0] en_o,
   output logic [CTRL_W-1:0]   rd_byte_o
);

   localparam int CW = $clog2(POR_CYCLES + 1);

   if (POR_CYCLES < 1) begin : g_bad_por
      $error("POR_CYCLES must be at least 1");
   end
   if (CH_COUNT < 1 || CH_COUNT > MAX_CH) begin : g_bad_ch
      $error("CH_COUNT out of range");
   end

   logic [CW-1:0] por_cnt;
   logic          pend_v;
   logic          pend_dir;

   assign ready_o = (por_cnt == CW'(POR_CYCLES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        por_cnt <= '0;
      else if (!ready_o) por_cnt <= por_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v   <= 1'b0;
         pend_dir <= 1'b0;
         dir_o    <= 1'b0;
      end else if (!ready_o) begin
         pend_v   <= 1'b0;
      end else if (commit_i) begin
         pend_v <= 1'b0;
         if (pend_v) dir_o <= pend_dir;
      end else if (drop_i) begin
         pend_v <= 1'b0;
      end else if (capt_i) begin
         pend_v   <= 1'b1;
         pend_dir <= capt_byte_i[DIR_BIT];
      end
   end

   for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
      logic pend_bit;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_bit <= 1'b0;
            en_o[c]  <= 1'b0;
         end else if (ready_o) begin
            if (commit_i && pend_v) en_o[c]  <= pend_bit;
            else if (capt_i)        pend_bit <= capt_byte_i[c];
         end
      end
   end

   always_comb begin
      rd_byte_o                = '0;
      rd_byte_o[DIR_BIT]       = dir_o;
      rd_byte_o[CH_COUNT-1:0]  = en_o;
   end

endmodule

// File: rtl/i2c_chanctl_target.sv
module i2c_chanctl_target
   import i2c_chanctl_pkg::*;
#(
   parameter int         CH_COUNT    = 4,
   parameter int         STRAP_W     = 3,
   parameter int         SYNC_STAGES = 2,
   parameter int         POR_CYCLES  = 64,
   parameter logic [3:0] ADDR_FIXED  = 4'b1110
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [STRAP_W-1:0]  strap_i,
   input  logic                scl_i,
   input  logic                sda_i,
   output logic                sda_pull_o,
   output logic                clk_dir_o,
   output logic [CH_COUNT-1:0] chan_en_o
);

   logic              scl_lvl;
   logic              sda_lvl;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_p;
   logic              stop_p;
   logic              ready;
   logic              capt;
   logic [CTRL_W-1:0] capt_byte;
   logic [CTRL_W-1:0] rd_byte;

   i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_o      (scl_lvl),
      .sda_o      (sda_lvl),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_p),
      .stop_o     (stop_p)
   );

   i2c_target_engine #(.ADDR_FIXED(ADDR_FIXED), .STRAP_W(STRAP_W)) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .ready_i     (ready),
      .strap_i     (strap_i),
      .sda_s_i     (sda_lvl),
      .scl_rise_i  (scl_rise),
      .scl_fall_i  (scl_fall),
      .start_i     (start_p),
      .stop_i      (stop_p),
      .rd_byte_i   (rd_byte),
      .pull_o      (sda_pull_o),
      .capt_o      (capt),
      .capt_byte_o (capt_byte)
   );

   chanctl_store #(.CH_COUNT(CH_COUNT), .POR_CYCLES(POR_CYCLES)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .capt_i      (capt),
      .capt_byte_i (capt_byte),
      .drop_i      (start_p),
      .commit_i    (stop_p),
      .ready_o     (ready),
      .dir_o       (clk_dir_o),
      .en_o        (chan_en_o),
      .rd_byte_o   (rd_byte)
   );

endmodule

// File: rtl/i2c_chanctl_checker.sv
module i2c_chanctl_checker #(
   parameter int CH_COUNT = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                scl_s,
   input logic                start_p,
   input logic                stop_p,
   input logic                ready,
   input logic                pull,
   input logic                dir,
   input logic [CH_COUNT-1:0] en
);

   // R8: the pull-low only asserts while the sampled clock is low
   assert_pull_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull) |-> !scl_s);

   // R5: register outputs move only right after a STOP
   assert_commit_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({dir, en}) |-> $past(stop_p));

   // R2: silent and cleared during the power-up window
   assert_por_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (!pull && !dir && (en == '0)));

   // R8: line free right after a frame boundary
   assert_free_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start_p || stop_p) |-> !pull);

endmodule

bind i2c_chanctl_target i2c_chanctl_checker #(.CH_COUNT(CH_COUNT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_s   (scl_lvl),
   .start_p (start_p),
   .stop_p  (stop_p),
   .ready   (ready),
   .pull    (sda_pull_o),
   .dir     (clk_dir_o),
   .en      (chan_en_o)
);

// File: tb/i2c_chanctl_target_test.sv
`timescale 1ns/1ps
module i2c_chanctl_target_test;

   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] strap = 3'd0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_line;
   logic       sda_pull_o;
   logic       clk_dir_o;
   logic [3:0] chan_en_o;

   int total = 0;
   int bad = 0;
   int clash = 0;
   int edge_viol = 0;
   logic prev_pull = 1'b0;

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_pull_o;

   i2c_chanctl_target uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap_i    (strap),
      .scl_i      (scl_m),
      .sda_i      (sda_line),
      .sda_pull_o (sda_pull_o),
      .clk_dir_o  (clk_dir_o),
      .chan_en_o  (chan_en_o)
   );

   // R8 monitor: pull may change only while the bus clock is low
   always @(negedge clk) begin
      if (rst_n && (sda_pull_o !== prev_pull) && scl_m) edge_viol++;
      prev_pull = sda_pull_o;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      sda_m = 1'b0; tick(2*Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      sda_m = 1'b1; tick(2*Q);
   endtask

   task automatic clock_bit(input logic b, output logic s);
      sda_m = b;    tick(Q);
      scl_m = 1'b1; tick(Q);
      s = sda_line; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clock_bit(d[i], s);
         if (s !== d[i]) clash++;
      end
      clock_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clock_bit(1'b1, s);
         d[i] = s;
      end
      clock_bit(~give_ack, s);
   endtask

   task automatic wr_txn(input logic [6:0] a, input logic [7:0] d, input logic do_stop,
                         output logic aa, output logic ad);
      bus_start();
      send_byte({a, 1'b0}, aa);
      send_byte(d, ad);
      if (do_stop) bus_stop();
   endtask

   task automatic rd_txn(input logic [6:0] a, input logic two, output logic aa,
                         output logic [7:0] b0, output logic [7:0] b1);
      bus_start();
      send_byte({a, 1'b1}, aa);
      recv_byte(two, b0);
      b1 = b0;
      if (two) recv_byte(1'b0, b1);
      bus_stop();
   endtask

   function automatic logic [7:0] shown(input logic [7:0] d);
      return {d[7], 3'b000, d[3:0]};
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic aa, ad;
      logic [7:0] b0, b1, d, cur;
      logic [6:0] good;

      tick(5);
      chk("R1 reset dir", 32'(clk_dir_o), 0);
      chk("R1 reset en", 32'(chan_en_o), 0);
      chk("R1 reset pull", 32'(sda_pull_o), 0);

      // R2: frame starting inside the power-up window is ignored
      rst_n = 1'b1;
      wr_txn({4'b1110, strap}, 8'h8F, 1'b1, aa, ad);
      chk("R2 no ack during power-up", 32'(aa), 0);
      chk("R2 outputs untouched", 32'({clk_dir_o, chan_en_o}), 0);
      tick(4*Q);

      // R3 sweep over every strap value
      cur = 8'h00;
      for (int s = 0; s < 8; s++) begin
         strap = 3'(s);
         good = {4'b1110, 3'(s)};
         for (int k = 0; k < 3; k++) begin
            wr_txn(good ^ 7'(1 << k), 8'hFF, 1'b1, aa, ad);
            chk("R3 low-bit mismatch no ack", 32'(aa), 0);
         end
         wr_txn(good ^ 7'h40, 8'hFF, 1'b1, aa, ad);
         chk("R3 fixed-bit mismatch no ack", 32'(aa), 0);
         chk("R3 mismatch leaves outputs", 32'({clk_dir_o, chan_en_o}), 32'({cur[7], cur[3:0]}));
         d = 8'(s * 37 + 3);
         wr_txn(good, d, 1'b1, aa, ad);
         chk("R3 match acked", 32'(aa), 1);
         chk("R10 data acked", 32'(ad), 1);
         tick(Q);
         cur = d;
         chk("R4 outputs after write", 32'({clk_dir_o, chan_en_o}), 32'({d[7], d[3:0]}));
      end

      // R4/R6/R9 sweep: every effective value, junk in bits 6..4
      strap = 3'd5;
      good = 7'b1110101;
      for (int i = 0; i < 32; i++) begin
         d = {i[4], 3'(i ^ 5), i[3:0]};
         clash = 0;
         wr_txn(good, d, 1'b1, aa, ad);
         chk("R9 ack with any direction bit", 32'(aa & ad), 1);
         chk("R8 no pull during controller bits", 32'(clash), 0);
         tick(Q);
         chk("R4 dir", 32'(clk_dir_o), 32'(d[7]));
         chk("R4 enables", 32'(chan_en_o), 32'(d[3:0]));
         rd_txn(good, 1'b0, aa, b0, b1);
         chk("R6 read ack", 32'(aa), 1);
         chk("R6 read value", 32'(b0), 32'(shown(d)));
         chk("R8 released after read", 32'(sda_pull_o), 0);
      end
      cur = d;

      // R5: no effect until STOP
      wr_txn(good, 8'h7A, 1'b0, aa, ad);
      tick(3*Q);
      chk("R5 held before stop", 32'({clk_dir_o, chan_en_o}), 32'({cur[7], cur[3:0]}));
      bus_stop();
      tick(Q);
      chk("R5 applied at stop", 32'({clk_dir_o, chan_en_o}), 32'({1'b0, 4'hA}));
      cur = 8'h0A;

      // R7: repeated START drops the pending byte
      wr_txn(good, 8'h85, 1'b0, aa, ad);
      rd_txn(good, 1'b0, aa, b0, b1);
      chk("R7 read after restart sees old", 32'(b0), 32'(shown(cur)));
      tick(Q);
      chk("R7 outputs keep old", 32'({clk_dir_o, chan_en_o}), 32'({cur[7], cur[3:0]}));

      // R6: controller ACK gets the byte again
      wr_txn(good, 8'hF3, 1'b1, aa, ad);
      rd_txn(good, 1'b1, aa, b0, b1);
      chk("R6 first byte", 32'(b0), 32'h83);
      chk("R6 repeated byte", 32'(b1), 32'h83);

      // R1: reset after a write clears the register
      tick(Q);
      rst_n = 1'b0;
      tick(3);
      chk("R1 reset clears", 32'({clk_dir_o, chan_en_o}), 0);
      rst_n = 1'b1;
      tick(100);
      rd_txn(good, 1'b0, aa, b0, b1);
      chk("R1 read zero after reset", 32'(b0), 0);

      chk("R8 pull changed only with clock low", 32'(edge_viol), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule